// File: doc/BRIEF.md
# Bouncing LED Scanner with Handshaked Helpers

This block sweeps a single lit position back and forth across a row of LEDs. A bit that reaches one end reverses and travels back. The sweep is a never-ending loop in a small controller. Each pass through the loop does three things. It decides the direction, it shifts the pattern, and then it calls two helper units in turn. The first helper latches the new pattern onto the LED outputs. The second holds the loop for a set number of milliseconds.

Each helper has the same three-signal control interface. The controller raises an enable, the helper shows ready when it can take an enable, and the helper pulses done when its work is finished. The top level uses the same interface towards its own user. A start input launches the loop and an idle output shows that a start will be taken. A result-valid output exists for interface symmetry, but it never rises because the loop does not return. The helper handshakes are brought out as outputs so that the sequencing can be observed.

The delay helper builds one millisecond from CLK_HZ/1000 clock cycles through a prescaler. A whole step therefore takes N + 5 cycles, where N = DELAY_MS * CLK_HZ / 1000.

Top module: `led_bounce_scanner`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `led_o` is 0, `idle_rdy` is 1, `result_vld` is 0, and both `wr_rdy` and `dly_rdy` are 1.
- R2: The internal pattern starts at value 1 with the direction flag clear. From the first step on, `led_o` holds exactly one set bit. Bit 0 is value 1 and bit LED_W-1 is the top end. With LED_W = 4 the values shown run 2, 4, 8, 4, 2, 1, 2, and so on.
- R3: Before each shift the direction is updated. A set flag with the pattern at the top end (8 for LED_W = 4) clears the flag. Otherwise, a clear flag with the pattern at 1 sets it. After this update the pattern shifts left when the flag is set and right when it is clear.
- R4: The first change of `led_o` appears 2 clock edges after the edge that accepts `start_en`. Each later change follows the one before by exactly N + 5 cycles, where N = DELAY_MS * CLK_HZ / 1000.
- R5: `idle_rdy` falls at the edge that accepts `start_en` and stays low until reset. Further `start_en` pulses have no effect on the LED values or on their timing.
- R6: The controller raises `wr_en` only while `wr_rdy` is high, and `dly_en` only while `dly_rdy` is high. Each enable lasts exactly one cycle. Each step issues exactly one write enable and one delay enable. Each done output is a single-cycle pulse.
- R7: `result_vld` is never asserted.
- R8: `led_o` changes only at the edge that follows a cycle with `wr_en` high. It holds its value through the whole delay.
- R9: A `start_en` that is high only while `rst` is high, or a `start_en` that is never raised, leaves the block idle with `led_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_en | input | 1 | Starts the scan loop when the block is idle |
| idle_rdy | output | 1 | High while a start will be accepted |
| result_vld | output | 1 | Result available; stays low |
| led_o | output | LED_W | LED drive, one set bit while scanning |
| wr_en | output | 1 | Enable from the controller to the LED-write helper |
| wr_rdy | output | 1 | LED-write helper can take an enable |
| wr_done | output | 1 | LED-write helper finished its write |
| dly_en | output | 1 | Enable from the controller to the delay helper |
| dly_rdy | output | 1 | Delay helper can take an enable |
| dly_done | output | 1 | Delay helper finished its wait |

## Verification
Two events can fall in the same cycle: a direction reversal at an end of the row and a shift of the pattern. The update rule has to apply the new flag before the shift, or else the bit leaves the row. A start pulse arriving while the loop runs can also meet a helper handshake in the same cycle. The bench sends random start pulses on every cycle of long runs that pass both ends several times. It also resets at a random point in the middle of a run. Every LED value and every interval between changes is compared with a bench model of the direction rule and the N + 5 step length.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_STEP     = 3'd1,
      ST_WR_REQ   = 3'd2,
      ST_WR_WAIT  = 3'd3,
      ST_DLY_REQ  = 3'd4,
      ST_DLY_WAIT = 3'd5
   } scan_state_e;

endpackage

// File: rtl/led_write_unit.sv
module led_write_unit #(
   parameter int LED_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [LED_W-1:0] data,
   output logic             rdy,
   output logic             done,
   output logic [LED_W-1:0] led
);

   logic             done_q;
   logic [LED_W-1:0] led_q;

   // The write completes in one cycle; ready drops while done is shown.
   always_ff @(posedge clk) begin
      if (rst) begin
         done_q <= 1'b0;
         led_q  <= '0;
      end else begin
         done_q <= en & ~done_q;
         if (en && !done_q) begin
            led_q <= data;
         end
      end
   end

   assign rdy  = ~done_q;
   assign done = done_q;
   assign led  = led_q;

endmodule

// File: rtl/ms_delay_unit.sv
module ms_delay_unit #(
   parameter int CLK_HZ = 50_000_000,
   parameter int MS_W   = 10
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            en,
   input  logic [MS_W-1:0] ms_in,
   output logic            rdy,
   output logic            done
);

   localparam int CYC_PER_MS = CLK_HZ / 1000;
   localparam int CPM_W      = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;

   logic            busy;
   logic            done_q;
   logic [MS_W-1:0] ms_left;
   logic            ms_tick;
   logic            take;

   assign rdy  = ~busy & ~done_q;
   assign take = en & rdy;

   generate
      if (CYC_PER_MS == 1) begin : g_no_presc
         assign ms_tick = busy;
      end else begin : g_presc
         logic [CPM_W-1:0] presc;
         always_ff @(posedge clk) begin
            if (rst) begin
               presc <= '0;
            end else if (take) begin
               presc <= CPM_W'(CYC_PER_MS - 1);
            end else if (busy) begin
               presc <= (presc == '0) ? CPM_W'(CYC_PER_MS - 1) : presc - 1'b1;
            end
         end
         assign ms_tick = busy && (presc == '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         busy    <= 1'b0;
         done_q  <= 1'b0;
         ms_left <= '0;
      end else begin
         done_q <= 1'b0;
         if (take) begin
            if (ms_in == '0) begin
               done_q <= 1'b1;
            end else begin
               busy    <= 1'b1;
               ms_left <= ms_in;
            end
         end else if (ms_tick) begin
            if (ms_left == MS_W'(1)) begin
               busy   <= 1'b0;
               done_q <= 1'b1;
            end else begin
               ms_left <= ms_left - 1'b1;
            end
         end
      end
   end

   assign done = done_q;

endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
   import led_scan_pkg::*;
#(
   parameter int LED_W    = 4,
   parameter int MS_W     = 10,
   parameter int DELAY_MS = 1000
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_en,
   input  logic             wr_rdy,
   input  logic             wr_done,
   input  logic             dly_rdy,
   input  logic             dly_done,
   output logic             idle_rdy,
   output logic             wr_en,
   output logic [LED_W-1:0] wr_data,
   output logic             dly_en,
   output logic [MS_W-1:0]  dly_ms
);

   localparam logic [LED_W-1:0] PAT_BOT = LED_W'(1);
   localparam logic [LED_W-1:0] PAT_TOP = LED_W'(1) << (LED_W - 1);

   scan_state_e      state;
   logic [LED_W-1:0] pat;
   logic             dir_up;
   logic             dir_nxt;

   // The flag is updated before the shift, so an end reverses the bit in the same step.
   always_comb begin
      if (dir_up && (pat == PAT_TOP)) begin
         dir_nxt = 1'b0;
      end else if (!dir_up && (pat == PAT_BOT)) begin
         dir_nxt = 1'b1;
      end else begin
         dir_nxt = dir_up;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         pat    <= PAT_BOT;
         dir_up <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start_en) state <= ST_STEP;
            end
            ST_STEP: begin
               dir_up <= dir_nxt;
               pat    <= dir_nxt ? (pat << 1) : (pat >> 1);
               state  <= ST_WR_REQ;
            end
            ST_WR_REQ: begin
               if (wr_rdy) state <= ST_WR_WAIT;
            end
            ST_WR_WAIT: begin
               if (wr_done) state <= ST_DLY_REQ;
            end
            ST_DLY_REQ: begin
               if (dly_rdy) state <= ST_DLY_WAIT;
            end
            ST_DLY_WAIT: begin
               if (dly_done) state <= ST_STEP;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign idle_rdy = (state == ST_IDLE);
   assign wr_en    = (state == ST_WR_REQ) && wr_rdy;
   assign dly_en   = (state == ST_DLY_REQ) && dly_rdy;
   assign wr_data  = pat;
   assign dly_ms   = MS_W'(DELAY_MS);

endmodule

// File: rtl/led_bounce_scanner.sv
module led_bounce_scanner #(
   parameter int LED_W    = 4,
   parameter int CLK_HZ   = 50_000_000,
   parameter int DELAY_MS = 1000
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_en,
   output logic             idle_rdy,
   output logic             result_vld,
   output logic [LED_W-1:0] led_o,
   output logic             wr_en,
   output logic             wr_rdy,
   output logic             wr_done,
   output logic             dly_en,
   output logic             dly_rdy,
   output logic             dly_done
);

   localparam int MS_W = (DELAY_MS > 1) ? $clog2(DELAY_MS + 1) : 1;

   generate
      if (LED_W < 2) begin : g_bad_width
         $error("led_bounce_scanner: LED_W must be at least 2");
      end
      if (CLK_HZ < 1000 || (CLK_HZ % 1000) != 0) begin : g_bad_clk
         $error("led_bounce_scanner: CLK_HZ must be a positive multiple of 1000");
      end
      if (DELAY_MS < 1) begin : g_bad_delay
         $error("led_bounce_scanner: DELAY_MS must be at least 1");
      end
   endgenerate

   logic [LED_W-1:0] wr_data;
   logic [MS_W-1:0]  dly_ms;

   scan_ctrl #(
      .LED_W    (LED_W),
      .MS_W     (MS_W),
      .DELAY_MS (DELAY_MS)
   ) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .start_en (start_en),
      .wr_rdy   (wr_rdy),
      .wr_done  (wr_done),
      .dly_rdy  (dly_rdy),
      .dly_done (dly_done),
      .idle_rdy (idle_rdy),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .dly_en   (dly_en),
      .dly_ms   (dly_ms)
   );

   led_write_unit #(
      .LED_W (LED_W)
   ) u_wr (
      .clk  (clk),
      .rst  (rst),
      .en   (wr_en),
      .data (wr_data),
      .rdy  (wr_rdy),
      .done (wr_done),
      .led  (led_o)
   );

   ms_delay_unit #(
      .CLK_HZ (CLK_HZ),
      .MS_W   (MS_W)
   ) u_dly (
      .clk   (clk),
      .rst   (rst),
      .en    (dly_en),
      .ms_in (dly_ms),
      .rdy   (dly_rdy),
      .done  (dly_done)
   );

   // The scan loop never returns, so no result is ever produced.
   assign result_vld = 1'b0;

endmodule

// File: rtl/led_bounce_scanner_chk.sv
module led_bounce_scanner_chk #(
   parameter int LED_W = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             idle_rdy,
   input logic             result_vld,
   input logic [LED_W-1:0] led_o,
   input logic             wr_en,
   input logic             wr_rdy,
   input logic             wr_done,
   input logic             dly_en,
   input logic             dly_rdy,
   input logic             dly_done
);

   a_r2_single_bit: assert property (@(posedge clk) disable iff (rst)
      $countones(led_o) <= 1);

   a_r2_first_value: assert property (@(posedge clk) disable iff (rst)
      ($past(led_o) == '0 && led_o != '0) |-> led_o == LED_W'(2));

   a_r3_neighbour_step: assert property (@(posedge clk) disable iff (rst)
      (!$stable(led_o) && $past(led_o) != '0) |->
         (led_o == ($past(led_o) << 1) || led_o == ($past(led_o) >> 1)));

   a_r5_no_return_to_idle: assert property (@(posedge clk) disable iff (rst)
      !idle_rdy |=> !idle_rdy);

   a_r6_wr_en_needs_rdy: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> wr_rdy);

   a_r6_wr_en_single: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> !wr_en);

   a_r6_dly_en_needs_rdy: assert property (@(posedge clk) disable iff (rst)
      dly_en |-> dly_rdy);

   a_r6_dly_en_single: assert property (@(posedge clk) disable iff (rst)
      dly_en |=> !dly_en);

   a_r6_wr_done_pulse: assert property (@(posedge clk) disable iff (rst)
      wr_done |=> !wr_done);

   a_r6_dly_done_pulse: assert property (@(posedge clk) disable iff (rst)
      dly_done |=> !dly_done);

   a_r7_no_result: assert property (@(posedge clk) disable iff (rst)
      !result_vld);

   a_r8_led_hold: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(led_o));

endmodule

bind led_bounce_scanner led_bounce_scanner_chk #(
   .LED_W (LED_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .idle_rdy   (idle_rdy),
   .result_vld (result_vld),
   .led_o      (led_o),
   .wr_en      (wr_en),
   .wr_rdy     (wr_rdy),
   .wr_done    (wr_done),
   .dly_en     (dly_en),
   .dly_rdy    (dly_rdy),
   .dly_done   (dly_done)
);

// File: tb/led_bounce_scanner_bench.sv
`timescale 1ns/1ps
module led_bounce_scanner_bench;

   localparam int LED_W    = 4;
   localparam int CLK_HZ   = 4000;
   localparam int DELAY_MS = 3;
   localparam int N_CYC    = DELAY_MS * (CLK_HZ / 1000);
   localparam int PERIOD   = N_CYC + 5;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             start_en = 1'b0;
   logic             idle_rdy, result_vld;
   logic [LED_W-1:0] led_o;
   logic             wr_en, wr_rdy, wr_done, dly_en, dly_rdy, dly_done;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  finished = 1'b0;

   always #2.5 clk = ~clk;

   led_bounce_scanner #(
      .LED_W    (LED_W),
      .CLK_HZ   (CLK_HZ),
      .DELAY_MS (DELAY_MS)
   ) u_led_bounce_scanner (
      .clk        (clk),
      .rst        (rst),
      .start_en   (start_en),
      .idle_rdy   (idle_rdy),
      .result_vld (result_vld),
      .led_o      (led_o),
      .wr_en      (wr_en),
      .wr_rdy     (wr_rdy),
      .wr_done    (wr_done),
      .dly_en     (dly_en),
      .dly_rdy    (dly_rdy),
      .dly_done   (dly_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // Model of one step: returns {new_dir, new_pattern}.
   function automatic logic [LED_W:0] model_step(input logic [LED_W-1:0] p, input logic d);
      logic nd;
      if (d && p == LED_W'(8)) nd = 1'b0;
      else if (!d && p == LED_W'(1)) nd = 1'b1;
      else nd = d;
      return {nd, nd ? (p << 1) : (p >> 1)};
   endfunction

   task automatic do_reset();
      rst = 1'b1;
      start_en = 1'b0;
      repeat (2) tick();
      start_en = 1'b1;           // R9: start while in reset must be ignored
      tick();
      chk(led_o == '0, "R1 led during reset", int'(led_o), 0);
      rst = 1'b0;
      start_en = 1'b0;
      tick();
      chk(led_o == '0,      "R1 led after reset", int'(led_o), 0);
      chk(idle_rdy == 1'b1, "R1 idle after reset", int'(idle_rdy), 1);
      chk(result_vld == 1'b0, "R1 result after reset", int'(result_vld), 0);
      chk(wr_rdy && dly_rdy, "R1 helpers ready", int'({wr_rdy, dly_rdy}), 3);
      chk(idle_rdy == 1'b1, "R9 start in reset ignored", int'(idle_rdy), 1);
   endtask

   task automatic run_scan(input int steps, input bit noisy);
      logic [LED_W-1:0] exp_pat = LED_W'(1);
      logic             exp_dir = 1'b0;
      logic [LED_W-1:0] prev = '0;
      logic [LED_W:0]   nx;
      int               waitn = $urandom_range(0, 6);
      int               cnt;
      int               n_wr, n_dly;
      bit               bad_rdy, saw_res, wr_last;
      repeat (waitn) begin
         tick();
         chk(led_o == '0 && idle_rdy, "R9 idle without start", int'(led_o), 0);
      end
      start_en = 1'b1;
      tick();
      start_en = 1'b0;
      chk(idle_rdy == 1'b0, "R5 idle drops on start", int'(idle_rdy), 0);
      cnt = 1;
      n_wr = 0; n_dly = 0; bad_rdy = 0; saw_res = 0; wr_last = 0;
      for (int s = 0; s < steps; s++) begin
         nx = model_step(exp_pat, exp_dir);
         exp_dir = nx[LED_W];
         exp_pat = nx[LED_W-1:0];
         while (led_o == prev && cnt < 400) begin
            wr_last = wr_en;
            if (wr_en) begin n_wr++; if (!wr_rdy) bad_rdy = 1; end
            if (dly_en) begin n_dly++; if (!dly_rdy) bad_rdy = 1; end
            if (result_vld) saw_res = 1;
            start_en = noisy ? 1'($urandom_range(0, 1)) : 1'b0;
            tick();
            cnt++;
            if (idle_rdy) bad_rdy = 1;
         end
         chk(led_o == exp_pat, (prev == 4'd8 || prev == 4'd1) ? "R3 reversal value" : "R2 scan value",
             int'(led_o), int'(exp_pat));
         chk(cnt == ((s == 0) ? 3 : PERIOD), "R4 step interval", cnt, (s == 0) ? 3 : PERIOD);
         chk(wr_last, "R8 change follows write enable", int'(wr_last), 1);
         chk(n_wr == 1 && n_dly == ((s == 0) ? 0 : 1), "R6 one enable per helper",
             n_wr * 10 + n_dly, (s == 0) ? 10 : 11);
         chk(!bad_rdy, "R5 R6 no idle return, enables only when ready", int'(bad_rdy), 0);
         chk(!saw_res, "R7 result stays low", int'(saw_res), 0);
         prev = led_o;
         cnt = 0; n_wr = 0; n_dly = 0; bad_rdy = 0; saw_res = 0;
      end
      start_en = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      do_reset();
      repeat (5) begin
         tick();
         chk(led_o == '0 && idle_rdy, "R9 stays idle with no start", int'(led_o), 0);
      end
      run_scan(9, 1'b0);
      do_reset();
      run_scan(13, 1'b1);
      do_reset();
      run_scan($urandom_range(2, 5), 1'b1);
      repeat ($urandom_range(1, PERIOD - 1)) tick();
      do_reset();
      run_scan(7, 1'b0);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL R4 watchdog expired actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule